// File: doc/BRIEF.md
# Pre-decoded Fetch Cache

This block is the fetch stage of a pipelined processor built around a direct-mapped instruction cache. Alongside each cached instruction word, every line keeps a class code and the address to fetch next. That next address is worked out once, while the line is being filled from a simple backing instruction memory. After that, the fetch stage follows the stored address and needs no adder or decoder in its loop.

When an ordinary instruction is followed by an unconditional jump, the fill logic gives the ordinary instruction the jump's destination. The jump is folded away and costs no cycle and no delay slot. A call-type jump (jump-and-link) still issues. It reports the return address (its own address plus 4) and raises a flag, because the link write competes for the register-file write port. A conditional branch line points at the branch destination, so fetch always predicts taken. The fall-through address is queued until the execute stage resolves the branch. A not-taken result kills the instruction presented that cycle, reports the fall-through address, and restarts fetch there on the next clock edge.

Top module: `pdf_fetch_cache`

## Requirements
- R1: A synchronous reset invalidates every cache line and sets `fetch_pc` to `RESET_VEC`. In the first cycle after reset, `fetch_valid`, `squash` and `imem_req` are low.
- R2: On a miss, `fetch_valid` stays low while the line is read from backing memory. `imem_req` stays high and `imem_addr` stays stable until `imem_ack`. Once the line is filled, a fetch presents the memory word at `fetch_pc` on `fetch_instr`.
- R3: Decoding uses instruction bits [31:26]: 2 is a jump, 3 is a call, 4 is a branch, and any other value is sequential. A target is the instruction's address plus 4 times the sign-extended bits [15:0]. `fetch_kind` reports 0 for sequential, 1 for call, 2 for branch and 3 for jump. After each delivered fetch with no squash, `fetch_pc` takes the value `next_pc` had in that cycle. A sequential instruction not followed by a jump has `next_pc` equal to its address plus 4.
- R4: A sequential instruction whose following word is a jump has `next_pc` equal to that jump's target. The jump itself is never delivered on that path.
- R5: A jump that is fetched directly, for example as a branch destination, reports kind 3 and `next_pc` equal to its own target.
- R6: A call reports kind 1, `next_pc` equal to its target, `link_addr` equal to its address plus 4, and `link_hazard` high.
- R7: A branch reports kind 2 and `next_pc` equal to its target, which is a taken prediction. Its address plus 4 is queued as its fall-through address.
- R8: A taken resolution (`res_valid` and `res_taken`) retires the oldest queued branch and does not disturb fetch.
- R9: A not-taken resolution while a branch is queued raises `squash` in that same cycle and holds `fetch_valid` low. `redirect_pc` equals the oldest queued fall-through address. `fetch_pc` equals that address on the next cycle, and all younger queued branches are dropped.
- R10: A branch is not delivered while `BQ_DEPTH` branches are unresolved, unless a taken resolution retires one in the same cycle.
- R11: A resolution that arrives while no branch is queued is ignored: `squash` stays low and fetch proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_req | output | 1 | Backing memory read request |
| imem_addr | output | 32 | Backing memory word address |
| imem_ack | input | 1 | Read data valid |
| imem_data | input | 32 | Read data |
| res_valid | input | 1 | Execute stage resolves the oldest branch |
| res_taken | input | 1 | Resolution outcome, 1 = taken |
| fetch_valid | output | 1 | Instruction delivered this cycle |
| fetch_pc | output | 32 | Address being fetched |
| fetch_instr | output | 32 | Instruction word |
| fetch_kind | output | 2 | Class code (0 sequential, 1 call, 2 branch, 3 jump) |
| next_pc | output | 32 | Pre-decoded next fetch address |
| link_addr | output | 32 | Return address for a call |
| link_hazard | output | 1 | Call delivered: register write-port conflict |
| squash | output | 1 | Kill of this cycle's fetch on a not-taken branch |
| redirect_pc | output | 32 | Restart address on squash |

## Verification
The hardest state to reach from the ports is a full branch queue sitting at a branch line that is already cached. Reaching it requires predicted-taken branches to pile up with no resolutions. The stimulus runs a loop that the predicted-taken path keeps closed, then withholds all resolutions for a window long enough for the queue to fill and fetch to park on the next branch. A second difficult case is a resolution that lands while the queue is empty. That case is forced right after reset, while the first line is still being filled. The bench's reference walker tracks the fetch address every cycle, so a kill, a redirect or a false stall shows up as soon as it happens.

// File: rtl/pdf_pkg.sv
`timescale 1ns/1ps
package pdf_pkg;
  localparam int AW   = 32;
  localparam int IW   = 32;
  localparam int OPW  = 6;
  localparam int OFFW = 16;

  localparam logic [OPW-1:0] OP_JUMP   = 6'd2;
  localparam logic [OPW-1:0] OP_CALL   = 6'd3;
  localparam logic [OPW-1:0] OP_BRANCH = 6'd4;

  typedef enum logic [1:0] {
    KIND_SEQ    = 2'd0,
    KIND_CALL   = 2'd1,
    KIND_BRANCH = 2'd2,
    KIND_JUMP   = 2'd3
  } kind_e;

  typedef struct packed {
    logic [IW-1:0] word;
    kind_e         kind;
    logic [AW-1:0] next;
    logic [AW-1:0] alt;
  } entry_t;

  function automatic kind_e op_kind(input logic [OPW-1:0] op);
    case (op)
      OP_JUMP:   return KIND_JUMP;
      OP_CALL:   return KIND_CALL;
      OP_BRANCH: return KIND_BRANCH;
      default:   return KIND_SEQ;
    endcase
  endfunction

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + AW'(4);
  endfunction

  function automatic logic [AW-1:0] rel_target(input logic [AW-1:0] a,
                                               input logic [OFFW-1:0] off);
    logic [AW-1:0] sx;
    sx = {{(AW-OFFW){off[OFFW-1]}}, off};
    return a + (sx << 2);
  endfunction
endpackage

// File: rtl/pdf_predecode.sv
`timescale 1ns/1ps
module pdf_predecode
  import pdf_pkg::*;
(
  input  logic [AW-1:0]   line_addr,
  input  logic [IW-1:0]   word0,
  input  logic            look_ok,
  input  logic [OPW-1:0]  look_op,
  input  logic [OFFW-1:0] look_off,
  output entry_t          ent,
  output logic            fold_hit
);
  kind_e         kind0;
  logic [AW-1:0] seq_a;
  logic [AW-1:0] own_tgt;

  always_comb begin
    kind0    = op_kind(word0[IW-1 -: OPW]);
    seq_a    = step_addr(line_addr);
    own_tgt  = rel_target(line_addr, word0[OFFW-1:0]);
    fold_hit = look_ok && (kind0 == KIND_SEQ) && (op_kind(look_op) == KIND_JUMP);
    ent.word = word0;
    ent.kind = kind0;
    ent.alt  = seq_a;
    if (kind0 != KIND_SEQ) ent.next = own_tgt;
    else if (fold_hit)     ent.next = rel_target(seq_a, look_off);
    else                   ent.next = seq_a;
  end
endmodule

// File: rtl/pdf_fill.sv
`timescale 1ns/1ps
module pdf_fill
  import pdf_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW-1:0]   start_addr,
  output logic            busy,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_ack,
  input  logic [IW-1:0]   mem_data,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [IW-1:0]   wr_word0,
  output logic            wr_look_ok,
  output logic [OPW-1:0]  wr_look_op,
  output logic [OFFW-1:0] wr_look_off
);
  typedef enum logic [1:0] {F_IDLE, F_FIRST, F_LOOK} fstate_e;

  fstate_e       st;
  logic [AW-1:0] fill_addr;
  logic [IW-1:0] word0_q;
  logic          first_is_seq;

  assign first_is_seq = (op_kind(mem_data[IW-1 -: OPW]) == KIND_SEQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= F_IDLE;
    end else begin
      case (st)
        F_IDLE:  if (start) st <= F_FIRST;
        F_FIRST: if (mem_ack) st <= first_is_seq ? F_LOOK : F_IDLE;
        F_LOOK:  if (mem_ack) st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == F_IDLE && start) fill_addr <= start_addr;
    if (st == F_FIRST && mem_ack) word0_q <= mem_data;
  end

  always_comb begin
    busy        = (st != F_IDLE);
    mem_req     = (st == F_FIRST) || (st == F_LOOK);
    mem_addr    = (st == F_LOOK) ? step_addr(fill_addr) : fill_addr;
    wr_en       = mem_ack && (((st == F_FIRST) && !first_is_seq) || (st == F_LOOK));
    wr_addr     = fill_addr;
    wr_word0    = (st == F_LOOK) ? word0_q : mem_data;
    wr_look_ok  = (st == F_LOOK);
    wr_look_op  = mem_data[IW-1 -: OPW];
    wr_look_off = mem_data[OFFW-1:0];
  end

  assert_req_held_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_start_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/pdf_store.sv
`timescale 1ns/1ps
module pdf_store
  import pdf_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-3:0] rd_line,
  output logic          rd_hit,
  output entry_t        rd_ent,
  input  logic          wr_en,
  input  logic [AW-3:0] wr_line,
  input  entry_t        wr_ent
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = AW - 2 - IDX_W;

  logic [LINES-1:0] vld;
  logic [TAG_W-1:0] tag_mem [LINES];
  entry_t           ent_mem [LINES];

  logic [IDX_W-1:0] ri, wi;
  assign ri = rd_line[IDX_W-1:0];
  assign wi = wr_line[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)        vld <= '0;
    else if (wr_en) vld[wi] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wi] <= wr_line[AW-3:IDX_W];
      ent_mem[wi] <= wr_ent;
    end
  end

  assign rd_hit = vld[ri] && (tag_mem[ri] == rd_line[AW-3:IDX_W]);
  assign rd_ent = ent_mem[ri];

  assert_fill_then_hit_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((rd_line != $past(wr_line)) || rd_hit));
endmodule

// File: rtl/pdf_brq.sv
`timescale 1ns/1ps
module pdf_brq
  import pdf_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_pc,
  input  logic          pop,
  input  logic          flush,
  output logic [AW-1:0] head_pc,
  output logic          nonempty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] slot [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wrap_inc(wr_ptr);
      if (pop)  rd_ptr <= wrap_inc(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (wr_ptr == PW'(s))) slot[s] <= push_pc;
    end
  end

  assign head_pc  = slot[rd_ptr];
  assign nonempty = (count != '0);
  assign full     = (count == CW'(DEPTH));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    pop |-> nonempty);
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> !nonempty);
endmodule

// File: rtl/pdf_fetch_cache.sv
`timescale 1ns/1ps
module pdf_fetch_cache
  import pdf_pkg::*;
#(
  parameter int            IDX_W     = 4,
  parameter int            BQ_DEPTH  = 2,
  parameter logic [AW-1:0] RESET_VEC = '0
) (
  input  logic          clk,
  input  logic          rst,
  output logic          imem_req,
  output logic [AW-1:0] imem_addr,
  input  logic          imem_ack,
  input  logic [IW-1:0] imem_data,
  input  logic          res_valid,
  input  logic          res_taken,
  output logic          fetch_valid,
  output logic [AW-1:0] fetch_pc,
  output logic [IW-1:0] fetch_instr,
  output logic [1:0]    fetch_kind,
  output logic [AW-1:0] next_pc,
  output logic [AW-1:0] link_addr,
  output logic          link_hazard,
  output logic          squash,
  output logic [AW-1:0] redirect_pc
);
  logic [AW-1:0] pc_q;
  logic          hit;
  entry_t        ent;

  logic          fill_busy, fill_start;
  logic          wr_en, wr_look_ok, fold_hit;
  logic [AW-1:0] wr_addr;
  logic [IW-1:0] wr_word0;
  logic [OPW-1:0]  wr_look_op;
  logic [OFFW-1:0] wr_look_off;
  entry_t        wr_ent;

  logic          bq_nonempty, bq_full;
  logic [AW-1:0] bq_head;
  logic          kill, bq_pop, bq_push, bq_block, fetch_ok;

  pdf_store #(.IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_line(pc_q[AW-1:2]), .rd_hit(hit), .rd_ent(ent),
    .wr_en(wr_en), .wr_line(wr_addr[AW-1:2]), .wr_ent(wr_ent)
  );

  pdf_fill u_fill (
    .clk(clk), .rst(rst),
    .start(fill_start), .start_addr(pc_q), .busy(fill_busy),
    .mem_req(imem_req), .mem_addr(imem_addr), .mem_ack(imem_ack), .mem_data(imem_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_word0(wr_word0),
    .wr_look_ok(wr_look_ok), .wr_look_op(wr_look_op), .wr_look_off(wr_look_off)
  );

  pdf_predecode u_pre (
    .line_addr(wr_addr), .word0(wr_word0),
    .look_ok(wr_look_ok), .look_op(wr_look_op), .look_off(wr_look_off),
    .ent(wr_ent), .fold_hit(fold_hit)
  );

  pdf_brq #(.DEPTH(BQ_DEPTH)) u_brq (
    .clk(clk), .rst(rst),
    .push(bq_push), .push_pc(ent.alt), .pop(bq_pop), .flush(kill),
    .head_pc(bq_head), .nonempty(bq_nonempty), .full(bq_full)
  );

  always_comb begin
    kill       = res_valid && !res_taken && bq_nonempty;
    bq_pop     = res_valid &&  res_taken && bq_nonempty;
    bq_block   = (ent.kind == KIND_BRANCH) && bq_full && !bq_pop;
    fetch_ok   = hit && !kill && !bq_block;
    bq_push    = fetch_ok && (ent.kind == KIND_BRANCH);
    fill_start = !hit && !fill_busy && !kill;
  end

  always_ff @(posedge clk) begin
    if (rst)           pc_q <= RESET_VEC;
    else if (kill)     pc_q <= bq_head;
    else if (fetch_ok) pc_q <= ent.next;
  end

  assign fetch_valid = fetch_ok;
  assign fetch_pc    = pc_q;
  assign fetch_instr = ent.word;
  assign fetch_kind  = ent.kind;
  assign next_pc     = ent.next;
  assign link_addr   = step_addr(pc_q);
  assign link_hazard = fetch_ok && (ent.kind == KIND_CALL);
  assign squash      = kill;
  assign redirect_pc = bq_head;

  assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> (fetch_pc == $past(next_pc)));
  assert_redirect_R9: assert property (@(posedge clk) disable iff (rst)
    squash |=> (fetch_pc == $past(redirect_pc)));
  assert_fold_seq_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && fold_hit) |-> (wr_ent.kind == KIND_SEQ));
endmodule

// File: tb/tb_pdf_fetch_cache.sv
`timescale 1ns/1ps
module tb_pdf_fetch_cache;
  localparam int DEPTH = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_req, imem_ack;
  logic [31:0] imem_addr, imem_data;
  logic        res_valid = 1'b0, res_taken = 1'b0;
  logic        fetch_valid, link_hazard, squash;
  logic [31:0] fetch_pc, fetch_instr, next_pc, link_addr, redirect_pc;
  logic [1:0]  fetch_kind;

  int checks = 0, failures = 0, delivered = 0, empty_res = 0;
  bit finished = 0;
  logic [31:0] exp_pc;
  logic [31:0] fq[$];

  always #10 clk = ~clk;

  pdf_fetch_cache #(.IDX_W(4), .BQ_DEPTH(DEPTH), .RESET_VEC(32'h0)) dut (
    .clk(clk), .rst(rst), .imem_req(imem_req), .imem_addr(imem_addr),
    .imem_ack(imem_ack), .imem_data(imem_data), .res_valid(res_valid),
    .res_taken(res_taken), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .fetch_instr(fetch_instr), .fetch_kind(fetch_kind), .next_pc(next_pc),
    .link_addr(link_addr), .link_hazard(link_hazard), .squash(squash),
    .redirect_pc(redirect_pc)
  );

  // program: word index i, m = i mod 16
  function automatic logic [31:0] prog(input logic [31:0] a);
    int unsigned i = a >> 2;
    int unsigned m = i % 16;
    if (m % 8 == 2) return {6'd2, 10'd0, 16'd3};
    if (m % 8 == 5) return {6'd3, 10'd0, 16'd2};
    if (m == 7)     return {6'd4, 10'd0, 16'd3};
    if (m == 15)    return {6'd4, 10'd0, 16'hFFF3};
    return {6'd0, 26'(i)};
  endfunction

  function automatic int ref_kind(input logic [31:0] w);
    case (w[31:26])
      6'd2: return 3;
      6'd3: return 1;
      6'd4: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] dest(input logic [31:0] a, input logic [31:0] w);
    int off = $signed(w[15:0]);
    return a + 32'(off * 4);
  endfunction

  function automatic logic [31:0] ref_next(input logic [31:0] a);
    logic [31:0] w = prog(a);
    if (ref_kind(w) != 0) return dest(a, w);
    if (ref_kind(prog(a + 4)) == 3) return dest(a + 4, prog(a + 4));
    return a + 4;
  endfunction

  always @(posedge clk) begin
    if (rst) imem_ack <= 1'b0;
    else if (imem_req && !imem_ack) begin
      imem_ack  <= 1'b1;
      imem_data <= prog(imem_addr);
    end else imem_ack <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_check(input bit rv, input bit rt);
    bit kill_exp = rv && !rt && (fq.size() > 0);
    int k;
    string nreq;
    chk(fetch_pc == exp_pc, "R3", "fetch_pc", fetch_pc, exp_pc);
    chk(squash == kill_exp, kill_exp ? "R9" : "R11", "squash", 32'(squash), 32'(kill_exp));
    if (rv && !rt && fq.size() == 0) empty_res++;
    if (kill_exp) begin
      chk(fetch_valid == 1'b0, "R9", "killed fetch_valid", 32'(fetch_valid), 0);
      chk(redirect_pc == fq[0], "R9", "redirect_pc", redirect_pc, fq[0]);
      exp_pc = fq[0];
      fq.delete();
    end else begin
      if (rv && rt && fq.size() > 0) void'(fq.pop_front());   // R8
      if (fetch_valid) begin
        delivered++;
        k = ref_kind(prog(exp_pc));
        chk(fetch_instr == prog(exp_pc), "R2", "fetch_instr", fetch_instr, prog(exp_pc));
        chk(fetch_kind == 2'(k), "R3", "fetch_kind", 32'(fetch_kind), 32'(k));
        case (k)
          1: nreq = "R6";
          2: nreq = "R7";
          3: nreq = "R5";
          default: nreq = (ref_next(exp_pc) != exp_pc + 4) ? "R4" : "R3";
        endcase
        chk(next_pc == ref_next(exp_pc), nreq, "next_pc", next_pc, ref_next(exp_pc));
        chk(link_hazard == (k == 1), "R6", "link_hazard", 32'(link_hazard), 32'(k == 1));
        if (k == 1) chk(link_addr == exp_pc + 4, "R6", "link_addr", link_addr, exp_pc + 4);
        if (k == 2) begin
          chk(fq.size() < DEPTH, "R10", "branch while queue full", fq.size(), DEPTH - 1);
          fq.push_back(exp_pc + 4);
        end
        exp_pc = ref_next(exp_pc);
      end
    end
  endtask

  task automatic step(input bit rv, input bit rt);
    @(posedge clk); #2;
    res_valid = rv; res_taken = rt;
    @(negedge clk);
    model_check(rv, rt);
  endtask

  task automatic do_reset();
    rst = 1'b1; res_valid = 1'b0; res_taken = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    exp_pc = 32'h0;
    fq.delete();
    chk(fetch_pc == 32'h0, "R1", "reset fetch_pc", fetch_pc, 0);
    chk(fetch_valid == 1'b0, "R1", "reset fetch_valid (lines invalid)", 32'(fetch_valid), 0);
    chk(squash == 1'b0, "R1", "reset squash", 32'(squash), 0);
    chk(imem_req == 1'b0, "R1", "reset imem_req", 32'(imem_req), 0);
  endtask

  task automatic run(input int n);
    int nres = 0;
    for (int c = 0; c < n; c++) begin
      if (c % 3 == 0) begin
        step(1'b1, (nres % 4) != 3);
        nres++;
      end else step(1'b0, 1'b0);
    end
  endtask

  initial begin
    do_reset();
    step(1'b1, 1'b0);               // R11: resolution with nothing queued
    run(1500);
    for (int c = 0; c < 60; c++) step(1'b0, 1'b0);
    chk(fq.size() == DEPTH, "R10", "queue occupancy", fq.size(), DEPTH);
    chk(fetch_valid == 1'b0, "R10", "stalled at branch", 32'(fetch_valid), 0);
    chk(ref_kind(prog(exp_pc)) == 2, "R10", "parked on branch", 32'(ref_kind(prog(exp_pc))), 2);
    run(300);
    do_reset();                     // R1: lines filled earlier must miss again
    run(300);
    chk(delivered > 300, "R2", "delivered fetches", delivered, 301);
    chk(empty_res > 0, "R11", "empty-queue resolutions", empty_res, 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule